// File: doc/BRIEF.md
# Dual Down-Counter Timer Window

The block places two independent down-counting timer channels and a small read-only identification area inside one 4 KB register window. Each channel is advanced by its own single-cycle tick-enable input, so the two channels may run at unrelated rates while sharing the bus clock. A channel has a reload value, a live count, a control byte, a sticky raw interrupt flag and a masked view of that flag. The two masked flags are ORed into one interrupt line.

Software reaches a channel through a 32-byte bank. It reads eight identification bytes from the top of the window. The integration-test locations are decoded but hold nothing. Reads return data combinationally in the cycle in which `bus_rd` is high. Writes take effect at the following clock edge.

Top module: `dual_timer_window`

## Requirements
- R1: Byte offsets 0x00-0x1F address channel 0 and 0x20-0x3F address channel 1, with bits [4:2] choosing the register inside the bank. 0x00 is the reload value: a write stores it and also sets the count. 0x04 is the count. 0x08 is the control byte. A write of any data to 0x0C clears the raw flag. 0x10 is the raw flag in bit 0. 0x14 is the raw flag ANDed with the interrupt enable. 0x18 writes the reload value without touching the count. Both 0x00 and 0x18 read back the reload value, and 0x0C and 0x1C read 0.
- R2: The control bits are: bit 0 one-shot, bit 1 32-bit width, bits [3:2] prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 run. After reset the control byte is 0x20, and the reload value, the count and the raw flag are all 0.
- R3: While the run bit is set, every prescaled tick lowers a nonzero count by one. The step from 1 to 0 sets the raw flag. With run clear the count holds.
- R4: A prescaled tick that finds the count at 0 acts by mode. With one-shot set (which overrides periodic) the count stays at 0. In periodic mode the count reloads from the reload value. With neither bit set (free-running) the count reloads to the full-scale value, 0xFFFF or 0xFFFFFFFF.
- R5: Prescale code 00 or 11 advances the count on every tick-enable cycle, 01 on every 16th and 10 on every 256th. Only tick-enable cycles with run set are counted, and the prescale phase restarts on every control write.
- R6: With bit 1 clear the count is 16 bits wide: a loaded count keeps only its low 16 bits, while the reload register keeps all 32.
- R7: If a clear write and a tick that sets the raw flag fall in the same cycle, the flag ends up set.
- R8: `irq_out` is high exactly when either channel has both its raw flag and its interrupt enable set.
- R9: Reads of 0xFE0 through 0xFFC return one byte per word, in the order 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The byte sits in bits [7:0] and bits [31:8] read 0.
- R10: Reads of the test locations 0xF00 and 0xF04, and of every other address outside the channel banks and the identification area, return 0.
- R11: Writes outside the two channel banks, and writes to a count register, change no readable state.
- R12: A tick-enable pulse for one channel has no effect on the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | NUM_CH (2) | Per-channel single-cycle tick enable |
| bus_wr | input | 1 | Write strobe, committed at the next rising edge |
| bus_rd | input | 1 | Read strobe, gates `bus_rdata` |
| bus_addr | input | 12 | Byte address inside the window; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, 0 when `bus_rd` is low |
| irq_out | output | 1 | Merged interrupt of both channels |

## Verification
The clocked properties assume that a bus write is the only thing that moves a stopped count or makes a running count jump by more than one step. For that reason every such property is excused in any cycle in which `bus_wr` is high. The bench never raises `bus_rd` and `bus_wr` together. It never lets a control write coincide with a tick, so each cycle has a single cause for a state change. Ticks are held high for counted stretches only after the mode and reload value are in place, so the expected count follows by plain arithmetic from the number of ticks.

// File: rtl/dtw_pkg.sv
`timescale 1ns/1ps
package dtw_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int BANK_BYTES = 32;
    localparam int PRE_W      = 8;
    localparam int CTRL_W     = 8;
    localparam int ID_COUNT   = 8;

    localparam int CTRL_ONESHOT_BIT = 0;
    localparam int CTRL_WIDE_BIT    = 1;
    localparam int CTRL_IE_BIT      = 5;
    localparam int CTRL_PERIOD_BIT  = 6;
    localparam int CTRL_RUN_BIT     = 7;

    // register select inside a channel bank (address bits [4:2])
    typedef enum logic [2:0] {
        SEL_RELOAD = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_RAW    = 3'd4,
        SEL_FLAG   = 3'd5,
        SEL_SHADOW = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       ie;
        logic       spare;
        logic [1:0] prescale;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } mode_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } chan_req_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(8'h20);

    function automatic mode_e ctrl_mode(input ctrl_t c);
        if (c.oneshot)       return MODE_ONESHOT;
        else if (c.periodic) return MODE_PERIODIC;
        else                 return MODE_FREE;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input ctrl_t c);
        return c.wide ? {DATA_W{1'b1}} : {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
    endfunction

    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
        case (code)
            2'b01:   return PRE_W'(8'h0F);
            2'b10:   return PRE_W'(8'hFF);
            default: return '0;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h04;
            3'd1:    return 8'h18;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dtw_prescaler.sv
`timescale 1ns/1ps
module dtw_prescaler
    import dtw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       advance,
    input  logic [1:0] div,
    output logic       pulse
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    assign limit = pre_limit(div);
    assign pulse = advance && ((phase_q & limit) == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtw_channel.sv
`timescale 1ns/1ps
module dtw_channel
    import dtw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  chan_req_t         req,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] count_o,
    output logic              raw_o
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic              raw_q;

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] count_step;
    logic              hit_zero;
    logic              pulse;
    logic              step;
    logic              wr_reload, wr_shadow, wr_ctrl, wr_ack;
    logic [DATA_W-1:0] read_mux;

    assign wmask = width_mask(ctrl_q);
    assign cur   = count_q & wmask;

    assign wr_reload = req.wr && (req.sel == SEL_RELOAD);
    assign wr_shadow = req.wr && (req.sel == SEL_SHADOW);
    assign wr_ctrl   = req.wr && (req.sel == SEL_CTRL);
    assign wr_ack    = req.wr && (req.sel == SEL_ACK);

    dtw_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (wr_ctrl),
        .advance (tick_en && ctrl_q.run),
        .div     (ctrl_q.prescale),
        .pulse   (pulse)
    );

    assign step = ctrl_q.run && pulse;

    always_comb begin
        count_step = cur;
        hit_zero   = 1'b0;
        if (cur == '0) begin
            case (ctrl_mode(ctrl_q))
                MODE_ONESHOT:  count_step = cur;
                MODE_PERIODIC: count_step = reload_q & wmask;
                default:       count_step = wmask;
            endcase
        end else begin
            count_step = cur - 1'b1;
            hit_zero   = (cur == DATA_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= '0;
            count_q  <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(req.wdata[CTRL_W-1:0]);
            end
            if (wr_reload || wr_shadow) begin
                reload_q <= req.wdata;
            end
            if (wr_reload) begin
                count_q <= req.wdata & wmask;
            end else if (step) begin
                count_q <= count_step;
            end
            // a terminal step outranks a clear in the same cycle
            if (step && hit_zero && !wr_reload) begin
                raw_q <= 1'b1;
            end else if (wr_ack) begin
                raw_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (req.sel)
            SEL_RELOAD, SEL_SHADOW: read_mux = reload_q;
            SEL_COUNT:              read_mux = cur;
            SEL_CTRL:               read_mux = DATA_W'(ctrl_q);
            SEL_RAW:                read_mux = DATA_W'(raw_q);
            SEL_FLAG:               read_mux = DATA_W'(raw_q && ctrl_q.ie);
            default:                read_mux = '0;
        endcase
    end

    assign rdata   = req.rd ? read_mux : '0;
    assign irq     = raw_q && ctrl_q.ie;
    assign ctrl_o  = ctrl_q;
    assign count_o = count_q;
    assign raw_o   = raw_q;

endmodule

// File: rtl/dtw_id_block.sv
`timescale 1ns/1ps
module dtw_id_block
    import dtw_pkg::*;
(
    input  logic [ADDR_W-1:2] word_addr,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = $clog2(ID_COUNT);
    localparam logic [ADDR_W-1:2] TEST_LO = (ADDR_W-2)'(12'hF00 >> 2);
    localparam logic [ADDR_W-1:2] TEST_HI = (ADDR_W-2)'(12'hF04 >> 2);

    logic id_hit;
    logic test_hit;

    assign id_hit   = (word_addr[ADDR_W-1:2+IDX_W] == '1);
    assign test_hit = (word_addr == TEST_LO) || (word_addr == TEST_HI);
    assign hit      = id_hit || test_hit;
    assign rdata    = id_hit ? DATA_W'(id_byte(word_addr[2+IDX_W-1:2])) : '0;

endmodule

// File: rtl/dual_timer_window.sv
`timescale 1ns/1ps
module dual_timer_window
    import dtw_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam int BANK_SHIFT = $clog2(BANK_BYTES);
    localparam int BANK_IDX_W = ADDR_W - BANK_SHIFT;

    logic [NUM_CH-1:0]             ch_hit;
    logic [NUM_CH-1:0]             ch_irq;
    logic [NUM_CH-1:0]             ch_raw;
    logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_count;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_rdata;
    reg_sel_e                      sel;
    logic                          misc_hit;
    logic [DATA_W-1:0]             misc_rdata;
    logic                          unused_lanes;

    assign sel          = reg_sel_e'(bus_addr[BANK_SHIFT-1:2]);
    assign unused_lanes = ^bus_addr[1:0];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        chan_req_t req;
        ctrl_t     ctrl_w;

        assign ch_hit[ch] = (bus_addr[ADDR_W-1:BANK_SHIFT] == BANK_IDX_W'(ch));
        assign req.wr     = bus_wr && ch_hit[ch];
        assign req.rd     = bus_rd && ch_hit[ch];
        assign req.sel    = sel;
        assign req.wdata  = bus_wdata;

        dtw_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick_en (tick_en[ch]),
            .req     (req),
            .rdata   (ch_rdata[ch]),
            .irq     (ch_irq[ch]),
            .ctrl_o  (ctrl_w),
            .count_o (ch_count[ch]),
            .raw_o   (ch_raw[ch])
        );

        assign ch_ctrl[ch] = ctrl_w;
    end

    dtw_id_block u_id (
        .word_addr (bus_addr[ADDR_W-1:2]),
        .hit       (misc_hit),
        .rdata     (misc_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ch_hit[ch]) begin
                bus_rdata = ch_rdata[ch];
            end
        end
        if (misc_hit && bus_rd) begin
            bus_rdata = misc_rdata;
        end
    end

    assign irq_out = |ch_irq;

endmodule

// File: rtl/dtw_checker.sv
`timescale 1ns/1ps
module dtw_checker
    import dtw_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            bus_wr,
    input logic                            bus_rd,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic                            irq_out,
    input logic [NUM_CH-1:0][CTRL_W-1:0]   ch_ctrl,
    input logic [NUM_CH-1:0][DATA_W-1:0]   ch_count,
    input logic [NUM_CH-1:0]               ch_raw
);

    logic [NUM_CH-1:0] masked;
    logic              unused_chk;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign masked[c] = ch_raw[c] && ch_ctrl[c][CTRL_IE_BIT];
    end

    assign unused_chk = ^{bus_addr[1:0], ch_ctrl};

    AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (rst)
        irq_out == (masked != '0)); // R8

    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[ADDR_W-1:5] == '1) |-> bus_rdata[DATA_W-1:8] == '0); // R9

    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr[ADDR_W-1:2] == 10'h3C0 || bus_addr[ADDR_W-1:2] == 10'h3C1))
        |-> bus_rdata == '0); // R10

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_HALT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
            (!ch_ctrl[c][CTRL_RUN_BIT] && !bus_wr) |=> $stable(ch_count[c])); // R3

        AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c][CTRL_RUN_BIT] && ch_ctrl[c][CTRL_WIDE_BIT] && !bus_wr && ch_count[c] != '0)
            |=> (ch_count[c] == $past(ch_count[c]) || ch_count[c] == $past(ch_count[c]) - 1'b1)); // R3

        AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c][CTRL_ONESHOT_BIT] && ch_count[c] == '0 && !bus_wr) |=> ch_count[c] == '0); // R4

        AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_raw[c]) |-> ch_count[c] == '0); // R3
    end

endmodule

bind dual_timer_window dtw_checker #(.NUM_CH(NUM_CH)) u_dtw_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .ch_ctrl   (ch_ctrl),
    .ch_count  (ch_count),
    .ch_raw    (ch_raw)
);

// File: tb/dual_timer_window_bench.sv
`timescale 1ns/1ps
module dual_timer_window_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  tick_en = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_timer_window u_dual_timer_window (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic ticks(input int ch, input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en[ch] = 1'b1;
            repeat (n) @(negedge clk);
            tick_en[ch] = 1'b0;
        end
    endtask

    task automatic expect_irq(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] id_exp [8];
        id_exp = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state of both channels
        for (int ch = 0; ch < 2; ch++) begin
            expect_rd("R2 reset ctrl", 12'(ch * 32 + 8), 32'h20);
            expect_rd("R2 reset reload", 12'(ch * 32), 32'h0);
            expect_rd("R2 reset count", 12'(ch * 32 + 4), 32'h0);
            expect_rd("R2 reset raw", 12'(ch * 32 + 16), 32'h0);
            expect_rd("R2 reset masked", 12'(ch * 32 + 20), 32'h0);
        end
        expect_irq("R2 reset irq", 1'b0);

        // R9 identification bytes
        for (int i = 0; i < 8; i++) begin
            expect_rd("R9 id byte", 12'(12'hFE0 + 4 * i), {24'd0, id_exp[i]});
        end

        // R10 sweep of everything between the banks and the id area
        for (int a = 12'h040; a < 12'hFE0; a += 4) begin
            expect_rd("R10 undecoded read", 12'(a), 32'h0);
        end

        // R11 writes outside banks and to the count register are ignored
        wr(12'h000, 32'h55);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h060, 32'hFFFF_FFFF);
        wr(12'hF00, 32'hFFFF_FFFF);
        wr(12'hFE0, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        wr(12'h004, 32'h1234);
        expect_rd("R11 ch0 reload kept", 12'h000, 32'h55);
        expect_rd("R11 ch0 count kept", 12'h004, 32'h55);
        expect_rd("R11 ch0 ctrl kept", 12'h008, 32'h20);
        expect_rd("R11 ch1 reload kept", 12'h020, 32'h0);
        expect_rd("R11 ch1 ctrl kept", 12'h028, 32'h20);
        expect_rd("R11 id kept", 12'hFE0, 32'h04);
        expect_rd("R11 test reg kept", 12'hF00, 32'h0);

        // R3 R4 periodic sweep over several reload values
        foreach (id_exp[k]) begin
            if (k < 3) begin
                int L;
                L = (k == 0) ? 1 : (k == 1 ? 3 : 6);
                wr(12'h008, 32'hE2);
                wr(12'h000, 32'(L));
                wr(12'h00C, 32'h0);
                for (int t = 1; t <= 2 * L + 3; t++) begin
                    ticks(0, 1);
                    expect_rd("R4 periodic count", 12'h004, 32'(L - (t % (L + 1))));
                    expect_rd("R3 raw flag", 12'h010, (t >= L) ? 32'h1 : 32'h0);
                    expect_irq("R8 irq follows flag", t >= L);
                end
            end
        end

        // R7 mask and clear behaviour
        wr(12'h008, 32'hC2);
        expect_rd("R7 raw without enable", 12'h010, 32'h1);
        expect_rd("R7 masked without enable", 12'h014, 32'h0);
        expect_irq("R8 irq masked", 1'b0);
        wr(12'h008, 32'hE2);
        expect_rd("R7 masked with enable", 12'h014, 32'h1);
        wr(12'h00C, 32'h0);
        expect_rd("R7 clear", 12'h010, 32'h0);
        expect_rd("R1 ack reads zero", 12'h00C, 32'h0);
        expect_irq("R8 irq after clear", 1'b0);

        // R7 set and clear in one cycle: set wins
        wr(12'h000, 32'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'h0; tick_en[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en[0] = 1'b0;
        expect_rd("R7 set beats clear", 12'h010, 32'h1);
        expect_rd("R7 count at zero", 12'h004, 32'h0);
        wr(12'h00C, 32'h0);

        // R4 one-shot
        wr(12'h008, 32'hA3);
        wr(12'h000, 32'h3);
        for (int t = 1; t <= 6; t++) begin
            ticks(0, 1);
            expect_rd("R4 oneshot count", 12'h004, (t >= 3) ? 32'h0 : 32'(3 - t));
            expect_rd("R4 oneshot raw", 12'h010, (t >= 3) ? 32'h1 : 32'h0);
        end
        wr(12'h008, 32'hE3);
        wr(12'h000, 32'h2);
        ticks(0, 4);
        expect_rd("R4 oneshot beats periodic", 12'h004, 32'h0);

        // R4 R6 free-running, 16-bit and 32-bit
        wr(12'h008, 32'hA0);
        wr(12'h000, 32'h12345);
        expect_rd("R6 count truncated", 12'h004, 32'h2345);
        expect_rd("R6 reload full width", 12'h000, 32'h12345);
        wr(12'h000, 32'h2);
        ticks(0, 2);
        expect_rd("R4 free16 zero", 12'h004, 32'h0);
        ticks(0, 1);
        expect_rd("R4 free16 wrap", 12'h004, 32'hFFFF);
        ticks(0, 1);
        expect_rd("R4 free16 next", 12'h004, 32'hFFFE);
        wr(12'h008, 32'hA2);
        wr(12'h000, 32'h1);
        ticks(0, 2);
        expect_rd("R4 free32 wrap", 12'h004, 32'hFFFF_FFFF);

        // R5 prescale codes
        wr(12'h008, 32'hC6);
        wr(12'h000, 32'd10);
        ticks(0, 15);
        expect_rd("R5 div16 before", 12'h004, 32'd10);
        ticks(0, 1);
        expect_rd("R5 div16 first", 12'h004, 32'd9);
        ticks(0, 48);
        expect_rd("R5 div16 later", 12'h004, 32'd6);
        wr(12'h008, 32'hCA);
        wr(12'h000, 32'd10);
        ticks(0, 255);
        expect_rd("R5 div256 before", 12'h004, 32'd10);
        ticks(0, 1);
        expect_rd("R5 div256 first", 12'h004, 32'd9);
        wr(12'h008, 32'hCE);
        wr(12'h000, 32'd10);
        ticks(0, 3);
        expect_rd("R5 code3 every tick", 12'h004, 32'd7);
        wr(12'h008, 32'h42);
        wr(12'h000, 32'd10);
        ticks(0, 20);
        expect_rd("R3 stopped holds", 12'h004, 32'd10);

        // R1 background reload
        wr(12'h008, 32'hC2);
        wr(12'h000, 32'd2);
        wr(12'h018, 32'd5);
        expect_rd("R1 shadow keeps count", 12'h004, 32'd2);
        expect_rd("R1 shadow sets reload", 12'h000, 32'd5);
        expect_rd("R1 shadow readback", 12'h018, 32'd5);
        expect_rd("R1 unused slot", 12'h01C, 32'h0);
        ticks(0, 3);
        expect_rd("R1 reload uses shadow", 12'h004, 32'd5);

        // R12 R8 independence and merged interrupt
        wr(12'h008, 32'h42);
        wr(12'h00C, 32'h0);
        wr(12'h000, 32'd4);
        wr(12'h028, 32'hE2);
        wr(12'h020, 32'd2);
        wr(12'h02C, 32'h0);
        ticks(1, 2);
        expect_rd("R12 ch1 counted", 12'h024, 32'h0);
        expect_rd("R12 ch1 raw", 12'h030, 32'h1);
        expect_rd("R12 ch0 untouched", 12'h004, 32'd4);
        expect_rd("R12 ch0 raw clear", 12'h010, 32'h0);
        expect_irq("R8 irq from ch1", 1'b1);
        wr(12'h02C, 32'h0);
        expect_irq("R8 irq cleared", 1'b0);
        wr(12'h008, 32'hE2);
        ticks(0, 4);
        expect_rd("R12 ch0 raw", 12'h010, 32'h1);
        expect_rd("R12 ch1 untouched", 12'h024, 32'h0);
        expect_irq("R8 irq from ch0", 1'b1);

        finish_run();
    end

endmodule